// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits beside an SDR SDRAM controller. When a power manager asks for sleep, it takes over the command pins and the clock-enable pin and puts the memory into its low-power self-refresh state. When the manager asks for wake, it brings the memory back out and hands it back in a state where normal traffic can resume.

Entry begins with a precharge of all banks. After the row-precharge time, the block issues the refresh command with the clock enable sampled low, which is what places the device in self refresh. From then on the clock enable stays low and the other pins rest at a no-operation pattern. The device must stay there for a minimum residency, and a wake request that arrives early is remembered until that minimum has passed. The block then waits for the clock to be reported stable before it raises the clock enable. After that it issues no-operation commands only, for the exit window. Last, it issues a configurable burst of auto-refresh commands, because the device's internal row counter has been moved by self refresh.

The ready output tells the main controller that it owns the bus again. All timings are parameters in clock cycles, and each one is clamped to a workable minimum.

Top module: `sdram_sleep_seq`

## Requirements
- R1: After reset, cke is 1, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), a10 is 0, ready is 1 and state_o is 0 (idle).
- R2: A sleep_req seen in idle drops ready in the next cycle. That same cycle carries PRECHARGE ALL: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1, with state_o=1.
- R3: The entry command (cs_n=0, ras_n=0, cas_n=0, we_n=1, with cke=0) comes exactly T_RP cycles after the precharge cycle (at least 1 cycle). The cycles between carry NOP, and state_o=2 during the entry cycle.
- R4: From the entry cycle until the exit, cke stays 0 without a break and every cycle after the entry cycle carries NOP. state_o is 3 while the block holds the device in self refresh.
- R5: A wake_req pulse is remembered. The number of consecutive cycles with cke=0, counted from the entry cycle, is max(max(w, T_RAS)+1, s)+1. Here w is the cycle offset of the wake pulse from the entry cycle, and s is the offset from which clk_stable is held 1.
- R6: cke rises only one cycle after clk_stable was seen at 1. While clk_stable is 0 after the residency and the wake, the block shows state_o=4 with cke=0.
- R7: After cke rises, NOP with cke=1 is issued for exactly max(T_XSR, 2) cycles before the first refresh command, with state_o=5.
- R8: After the exit window, N_REF auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1, with cke=1) are issued exactly T_RFC cycles apart, with state_o=6.
- R9: ready and state_o=0 return exactly T_RFC cycles after the last auto-refresh command.
- R10: A sleep_req outside idle, and a wake_req in idle, have no effect. The sequence timing is unchanged, and in idle ready stays 1 and cke stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self refresh, taken only in idle |
| wake_req | input | 1 | Request to leave self refresh, held until the residency ends |
| clk_stable | input | 1 | Clock reported stable; gates the rise of cke |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; high selects all banks for precharge |
| ready | output | 1 | Bus handed back to the main controller |
| state_o | output | 3 | Phase code: 0 idle, 1 precharge, 2 enter, 3 in self refresh, 4 wait clock, 5 exit NOP, 6 refresh |

## Verification
A wrong phase register or a timer that counts wrong shows at the pins within one phase. The pin can be an early or late rise of cke, a precharge-to-entry gap that differs from T_RP, a short or long run of NOPs before the first refresh, or refresh commands spaced other than T_RFC apart. A lost wake latch shows as a sequence that never leaves self refresh, and the run then ends on the watchdog. A missing clock gate shows as cke rising while clk_stable is still low, one cycle after the residency ends. The bench measures every interval at the pins for each sequence. It compares the measured value with the formula in the requirement, so any of these faults fails in the sequence where it first occurs.

// File: rtl/sdram_sleep_pkg.sv
package sdram_sleep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRE    = 3'd1,
    ST_ENTER  = 3'd2,
    ST_IN_SR  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_EXIT   = 3'd5,
    ST_REFR   = 3'd6
  } sr_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sleep_rst_sync.sv
module sleep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sleep_timer.sv
module sleep_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;
  assign cnt_d  = load ? load_val : (cnt_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sleep_evt_cnt.sv
module sleep_evt_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  assign val_en = clr | inc;
  assign val_d  = clr ? '0 : (val_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/sleep_cmd_enc.sv
module sleep_cmd_enc
  import sdram_sleep_pkg::*;
(
  input  sr_state_t state,
  input  logic      slot,
  output logic      cke,
  output sd_cmd_t   cmd,
  output logic      a10
);
  always_comb begin
    cmd = CMD_NOP;
    a10 = 1'b0;
    cke = 1'b1;
    unique case (state)
      ST_PRE:   if (slot) begin cmd = CMD_PRE; a10 = 1'b1; end
      ST_ENTER: begin cmd = CMD_REF; cke = 1'b0; end
      ST_IN_SR: cke = 1'b0;
      ST_WAIT:  cke = 1'b0;
      ST_REFR:  if (slot) cmd = CMD_REF;
      default:  ;
    endcase
  end
endmodule

// File: rtl/sdram_sleep_seq.sv
module sdram_sleep_seq
  import sdram_sleep_pkg::*;
#(
  parameter int T_RAS = 5,
  parameter int T_RP  = 2,
  parameter int T_XSR = 8,
  parameter int T_RFC = 7,
  parameter int N_REF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       clk_stable,
  output logic       cke,
  output logic       cs_n,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic       a10,
  output logic       ready,
  output logic [2:0] state_o
);
  localparam int RAS_EFF  = max2(T_RAS, 1);
  localparam int RP_EFF   = max2(T_RP, 1);
  localparam int XSR_EFF  = max2(T_XSR, 2);
  localparam int RFC_EFF  = max2(T_RFC, 1);
  localparam int NREF_EFF = max2(N_REF, 1);
  localparam int MAX_DUR  = max2(max2(RAS_EFF, RP_EFF), max2(XSR_EFF, RFC_EFF));
  localparam int CNT_W    = max2($clog2(MAX_DUR + 1), 1);
  localparam int RC_W     = max2($clog2(NREF_EFF + 1), 1);

  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(RAS_EFF - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(RP_EFF - 1);
  localparam logic [CNT_W-1:0] LD_XSR = CNT_W'(XSR_EFF - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(RFC_EFF - 1);
  localparam logic [RC_W-1:0]  LAST_REF = RC_W'(NREF_EFF - 1);

  logic             rst_ni;
  sr_state_t        state_q, state_d;
  logic             slot_q, slot_d;
  logic             wake_q, wake_d, wake_en;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             rc_clr, rc_inc;
  logic [RC_W-1:0]  rc_val;
  sd_cmd_t          cmd;

  sleep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  sleep_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sleep_evt_cnt #(.W(RC_W)) u_refcnt (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (rc_clr),
    .inc   (rc_inc),
    .value (rc_val)
  );

  sleep_cmd_enc u_enc (
    .state (state_q),
    .slot  (slot_q),
    .cke   (cke),
    .cmd   (cmd),
    .a10   (a10)
  );

  // next-state and timer control
  always_comb begin
    state_d  = state_q;
    slot_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rc_clr   = 1'b0;
    rc_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
          slot_d   = 1'b1;
        end
      end
      ST_PRE: begin
        if (tmr_zero) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        state_d  = ST_IN_SR;
        tmr_load = 1'b1;
        tmr_val  = LD_RAS;
      end
      ST_IN_SR: begin
        if (tmr_zero && (wake_q || wake_req)) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (clk_stable) begin
          state_d  = ST_EXIT;
          tmr_load = 1'b1;
          tmr_val  = LD_XSR;
        end
      end
      ST_EXIT: begin
        if (tmr_zero) begin
          state_d  = ST_REFR;
          tmr_load = 1'b1;
          tmr_val  = LD_RFC;
          slot_d   = 1'b1;
          rc_clr   = 1'b1;
        end
      end
      ST_REFR: begin
        if (tmr_zero) begin
          if (rc_val == LAST_REF) begin
            state_d = ST_IDLE;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = LD_RFC;
            slot_d   = 1'b1;
            rc_inc   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // wake latch: armed during entry and residency, cleared when residency ends
  always_comb begin
    wake_en = 1'b0;
    wake_d  = wake_q;
    if (state_q == ST_IN_SR && state_d != ST_IN_SR) begin
      wake_en = 1'b1;
      wake_d  = 1'b0;
    end else if (wake_req && (state_q == ST_PRE || state_q == ST_ENTER ||
                              state_q == ST_IN_SR)) begin
      wake_en = 1'b1;
      wake_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      wake_q <= 1'b0;
    else if (wake_en) wake_q <= wake_d;
  end

  assign cs_n    = cmd.cs_n;
  assign ras_n   = cmd.ras_n;
  assign cas_n   = cmd.cas_n;
  assign we_n    = cmd.we_n;
  assign ready   = (state_q == ST_IDLE);
  assign state_o = state_q;
endmodule

// File: rtl/sdram_sleep_chk.sv
module sdram_sleep_chk #(
  parameter int T_RAS = 5,
  parameter int T_XSR = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       clk_stable,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       ready,
  input logic [2:0] state_o
);
  localparam int RAS_MIN = ((T_RAS > 1) ? T_RAS : 1) + 1;
  localparam int XSR_MIN = (T_XSR > 2) ? T_XSR : 2;

  logic [15:0] low_cnt;
  logic [15:0] high_cnt;
  logic        is_nop, is_ref;

  assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
  assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= 16'hFFFF;
    end else begin
      if (cke) low_cnt <= '0;
      else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
      if (!cke) high_cnt <= '0;
      else if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 1'b1;
    end
  end

  AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(sleep_req)); // R2

  AST_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> is_ref); // R3

  AST_NOP_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$fell(cke)) |-> is_nop); // R4

  AST_STATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |-> !cke); // R4

  AST_MIN_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_cnt >= 16'(RAS_MIN + 1))); // R5

  AST_CLK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable)); // R6

  AST_EXIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_ref) |-> (high_cnt >= 16'(XSR_MIN))); // R7
endmodule

bind sdram_sleep_seq sdram_sleep_chk #(.T_RAS(T_RAS), .T_XSR(T_XSR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_req  (sleep_req),
  .clk_stable (clk_stable),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ready      (ready),
  .state_o    (state_o)
);

// File: tb/tb_sdram_sleep_seq.sv
`timescale 1ns/1ps
module tb_sdram_sleep_seq;
  localparam int T_RAS = 5;
  localparam int T_RP  = 3;
  localparam int T_XSR = 1;
  localparam int T_RFC = 4;
  localparam int N_REF = 3;

  logic clk, rst_n, sleep_req, wake_req, clk_stable;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, ready;
  logic [2:0] state_o;

  int n_tests, n_fail;
  bit done;

  sdram_sleep_seq #(.T_RAS(T_RAS), .T_RP(T_RP), .T_XSR(T_XSR), .T_RFC(T_RFC),
                    .N_REF(N_REF)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ready(ready), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_low(input int wd, input int sd);
    return imax(imax(wd, T_RAS) + 1, sd) + 1;
  endfunction

  function automatic int exp_xsr();
    return imax(T_XSR, 2);
  endfunction

  function automatic bit pins_nop();
    return {cs_n, ras_n, cas_n, we_n} == 4'b0111;
  endfunction

  function automatic bit pins_pre();
    return {cs_n, ras_n, cas_n, we_n} == 4'b0010;
  endfunction

  function automatic bit pins_ref();
    return {cs_n, ras_n, cas_n, we_n} == 4'b0001;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int wd, input int sd, input bit noise);
    int cnt, bad, low, refs, gap;
    @(negedge clk);
    clk_stable = (sd == 0);
    sleep_req  = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(ready == 1'b0, "R2 ready low", ready, 0);
    chk(pins_pre() && a10 && cke, "R2 precharge all", {cs_n, ras_n, cas_n, we_n, a10}, 5'b00101);
    chk(state_o == 3'd1, "R2 state", state_o, 1);
    cnt = 0; bad = 0;
    while (!(pins_ref() && !cke)) begin
      @(negedge clk);
      cnt++;
      if (!(pins_ref() && !cke) && !pins_nop()) bad++;
    end
    chk(cnt == T_RP, "R3 precharge to entry", cnt, T_RP);
    chk(bad == 0, "R3 nop gap", bad, 0);
    chk(state_o == 3'd2, "R3 entry state", state_o, 2);
    low = 1; bad = 0;
    for (int i = 0; ; i++) begin
      wake_req   = (i == wd);
      clk_stable = (i >= sd);
      if (noise && i == 1) sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      wake_req  = 1'b0;
      if (cke) break;
      low++;
      if (!pins_nop()) bad++;
      if (low == exp_low(wd, sd) && state_o != 3'd4) bad++;
      if (i == 0 && state_o != 3'd3) bad++;
    end
    chk(bad == 0, "R4 nop and state while low", bad, 0);
    chk(low == exp_low(wd, sd), "R5 cke low length", low, exp_low(wd, sd));
    if (sd > imax(wd, T_RAS) + 1)
      chk(low == sd + 1, "R6 clock gate", low, sd + 1);
    clk_stable = 1'b1;
    chk(state_o == 3'd5, "R7 exit state", state_o, 5);
    cnt = 0; bad = 0;
    while (!pins_ref()) begin
      cnt++;
      if (!pins_nop() || !cke) bad++;
      @(negedge clk);
    end
    chk(cnt == exp_xsr() && bad == 0, "R7 exit nop window", cnt, exp_xsr());
    chk(state_o == 3'd6 && cke, "R8 refresh state", state_o, 6);
    refs = 1; gap = 0; bad = 0;
    forever begin
      if (noise && gap == 0 && refs == 1) sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      gap++;
      if (pins_ref()) begin
        if (gap != T_RFC) bad++;
        refs++;
        gap = 0;
      end
      if (ready) break;
    end
    chk(refs == N_REF && bad == 0, "R8 refresh count and spacing", refs, N_REF);
    chk(gap == T_RFC, "R9 ready after last refresh", gap, T_RFC);
    chk(state_o == 3'd0, "R9 idle state", state_o, 0);
    if (noise) begin
      @(negedge clk);
      chk(ready && cke && state_o == 3'd0, "R10 ignored sleep_req", state_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed, wd, sd;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; clk_stable = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cke && pins_nop() && !a10 && ready && state_o == 3'd0, "R1 reset state",
        {cke, cs_n, ras_n, cas_n, we_n, a10, ready}, 7'b1011101);

    // wake in idle
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready && cke && state_o == 3'd0, "R10 ignored wake_req", state_o, 0);

    // directed corners
    run_seq(0, 0, 1'b0);
    run_seq(T_RAS - 1, 0, 1'b0);
    run_seq(T_RAS, 0, 1'b0);
    run_seq(T_RAS + 3, 0, 1'b0);
    run_seq(0, T_RAS + 9, 1'b0);
    run_seq(2, 1, 1'b1);

    seed = $urandom(32'd20240611);
    seed = seed;
    for (int k = 0; k < 24; k++) begin
      wd = $urandom_range(T_RAS + 4, 0);
      sd = $urandom_range(T_RAS + 8, 0);
      run_seq(wd, sd, ($urandom_range(3, 0) == 0));
      repeat ($urandom_range(3, 0)) @(negedge clk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule